// File: doc/BRIEF.md
# Application Bus Transfer Master

This block moves one packet of endpoint data between a serial-bus device core and the application logic. It is the master of a plain command/acknowledge bus. To fetch data that the host will read, it issues a run of read cycles. To hand over data that the host has written, it issues a run of write cycles and then one status write. Each cycle carries a command strobe, a 16-bit byte address, a read/not-write flag, 32-bit write data, four byte enables and a burst marker. The application completes a cycle with ack, err or abort. With ack it also returns read data and byte enables.

The core starts a packet with a one-cycle start pulse. The pulse carries the direction, the base address, the byte length and the address of the status word. The block then runs the packet to its end and reports one of three outcomes with a one-cycle pulse:

- **Completed**: every cycle was acknowledged.
- **Retry**: the application refused a cycle with err. The core may replay the whole packet later.
- **Dropped**: the application aborted. The packet is discarded.

For outgoing words, the core supplies the data combinationally for the word index that the block exposes.

Top module: `appbus_xfer_master`

## Requirements
- R1: During and directly after reset, no command is driven. Busy and all outcome pulses are low.
- R2: An accepted start raises the command strobe on the next cycle. Data word n goes to address base+4n (modulo 2^16). The read/not-write flag is 1 for a fetch packet and 0 for a deliver packet. Busy equals the command strobe.
- R3: While a cycle waits with none of ack/err/abort, the strobe, address, flag, byte enables, burst marker and write data hold their values.
- R4: The burst marker is 1 on every data word except the last. It is 0 on a single-word packet and on the status write.
- R5: Byte enables are 1111 on every word except the last. On the last word they follow the length modulo 4: 0 gives 1111, 1 gives 0001, 2 gives 0011, 3 gives 0111. Bit 0 marks the lowest byte.
- R6: An acknowledged read gives a one-cycle in-valid pulse on the next cycle. The pulse carries the returned data and byte enables.
- R7: After the last deliver word is acknowledged, a status write follows. It goes to the status address with flag 0, data equal to the byte length, enables 1111 and burst 0. Its ack pulses completed.
- R8: err ends the packet on the next cycle, with no further cycles, and pulses retry once.
- R9: abort ends the packet on the next cycle and pulses dropped. This holds in the status phase too, and no completed pulse is given.
- R10: When responses coincide, abort wins over err and err wins over ack. An ack that loses produces no read data and no progress.
- R11: A start pulse while busy is ignored.
- R12: A zero-length fetch packet pulses completed one cycle after start with no bus cycle. A zero-length deliver packet issues only the status write.
- R13: After the last fetch word is acknowledged, completed pulses on the next cycle and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_pkt_start | input | 1 | One-cycle packet start request |
| i_pkt_rd | input | 1 | 1 = fetch with reads, 0 = deliver with writes |
| i_pkt_addr | input | 16 | Base byte address of the packet |
| i_pkt_len | input | 11 | Packet length in bytes |
| i_stat_addr | input | 16 | Address of the status write |
| i_out_word | input | 32 | Outgoing word for index o_word_idx |
| o_word_idx | output | 11 | Index of the word on the bus |
| o_busy | output | 1 | Packet in progress |
| o_in_valid | output | 1 | Fetched word valid pulse |
| o_in_data | output | 32 | Fetched word |
| o_in_ben | output | 4 | Byte enables of the fetched word |
| o_pkt_done | output | 1 | Packet completed pulse |
| o_pkt_retry | output | 1 | Packet refused, retry later, pulse |
| o_pkt_drop | output | 1 | Packet aborted pulse |
| o_cmd_valid | output | 1 | Bus command strobe |
| o_addr | output | 16 | Bus byte address |
| o_rnw | output | 1 | Bus read/not-write |
| o_wdata | output | 32 | Bus write data |
| o_ben | output | 4 | Bus byte enables |
| o_burst | output | 1 | Bus burst marker |
| i_ack | input | 1 | Application completes the cycle |
| i_err | input | 1 | Application refuses the cycle |
| i_abort | input | 1 | Application abandons the packet |
| i_rdata | input | 32 | Read data |
| i_rben | input | 4 | Read byte enables |

## Verification
The hardest situations to reach from the ports are these:

- an abort that lands on the status write, after every data word has been accepted;
- responses that coincide on one cycle;
- a start that arrives while a cycle is stalled.

The bench gets there with a scripted list of responses. The responder takes one entry for each cycle the block presents, so a test can place wait states, err, abort or any mix of them on a chosen word or on the status write. A behavioural model, fed the same list, predicts every output on every clock.

// File: rtl/appbus_xfer_pkg.sv
// Shared types for the application bus transfer master.
// Assumes nothing beyond a single clock domain.
package appbus_xfer_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STAT} xfer_state_t;
    typedef enum logic [1:0] {RSP_NONE, RSP_ACK, RSP_ERR, RSP_ABORT} xfer_resp_t;
endpackage

// File: rtl/xfer_resp_arb.sv
// Folds the three slave replies into one code with fixed priority:
// abort over err over ack. Replies outside a cycle are ignored.
// Assumes replies are only meaningful while the command strobe is high.
module xfer_resp_arb
    import appbus_xfer_pkg::*;
(
    input  logic       cmd_active,
    input  logic       ack,
    input  logic       err,
    input  logic       abort,
    output xfer_resp_t resp
);
    // Priority selection of the reply
    always_comb begin
        resp = RSP_NONE;
        if (cmd_active) begin
            if (abort)    resp = RSP_ABORT;
            else if (err) resp = RSP_ERR;
            else if (ack) resp = RSP_ACK;
        end
    end
endmodule

// File: rtl/xfer_beat_gen.sv
// Derives the per-word bus fields from the packet base, length and
// word index: byte address, byte enables and last-word flag.
// Assumes len is non-zero whenever the fields are used.
module xfer_beat_gen #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 11,
    localparam int BEN_W = DATA_W / 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic [BEN_W-1:0]  ben,
    output logic              last
);
    localparam int SH = $clog2(BEN_W);

    logic [LEN_W:0]   nwords;
    logic [SH-1:0]    rem;
    logic [BEN_W-1:0] tail_ben;

    // Word count, remainder, address and last-word decision
    always_comb begin
        nwords = ({1'b0, len} + (LEN_W+1)'(BEN_W-1)) >> SH;
        rem    = len[SH-1:0];
        last   = ({1'b0, idx} == (nwords - (LEN_W+1)'(1)));
        addr   = base + (ADDR_W'(idx) << SH);
    end

    // One enable bit per byte lane of the final word
    for (genvar b = 0; b < BEN_W; b++) begin : g_tail
        assign tail_ben[b] = (rem == '0) || (SH'(b) < rem);
    end

    assign ben = last ? tail_ben : '1;
endmodule

// File: rtl/xfer_ctrl.sv
// Packet sequencer: accepts a start, steps through the data words,
// adds the status write for deliver packets and raises one outcome pulse.
// Assumes the reply code is already prioritised.
module xfer_ctrl
    import appbus_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 11,
    localparam int BEN_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [ADDR_W-1:0] start_stat,
    input  xfer_resp_t        resp,
    input  logic              last,
    input  logic [DATA_W-1:0] rdata,
    input  logic [BEN_W-1:0]  rben,
    output xfer_state_t       state,
    output logic [ADDR_W-1:0] base,
    output logic [LEN_W-1:0]  len,
    output logic [LEN_W-1:0]  idx,
    output logic              rd,
    output logic [ADDR_W-1:0] stat_addr,
    output logic              done,
    output logic              retry,
    output logic              drop,
    output logic              in_valid,
    output logic [DATA_W-1:0] in_data,
    output logic [BEN_W-1:0]  in_ben
);
    // Sequencing state, packet context and outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base      <= '0;
            len       <= '0;
            idx       <= '0;
            rd        <= 1'b0;
            stat_addr <= '0;
            done      <= 1'b0;
            retry     <= 1'b0;
            drop      <= 1'b0;
            in_valid  <= 1'b0;
            in_data   <= '0;
            in_ben    <= '0;
        end else begin
            done     <= 1'b0;
            retry    <= 1'b0;
            drop     <= 1'b0;
            in_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        base      <= start_addr;
                        len       <= start_len;
                        rd        <= start_rd;
                        stat_addr <= start_stat;
                        idx       <= '0;
                        if (start_len == '0) begin
                            if (start_rd) done  <= 1'b1;
                            else          state <= ST_STAT;
                        end else begin
                            state <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    unique case (resp)
                        RSP_ABORT: begin drop  <= 1'b1; state <= ST_IDLE; end
                        RSP_ERR:   begin retry <= 1'b1; state <= ST_IDLE; end
                        RSP_ACK: begin
                            if (rd) begin
                                in_valid <= 1'b1;
                                in_data  <= rdata;
                                in_ben   <= rben;
                            end
                            if (last) begin
                                if (rd) begin
                                    done  <= 1'b1;
                                    state <= ST_IDLE;
                                end else begin
                                    state <= ST_STAT;
                                end
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_STAT: begin
                    unique case (resp)
                        RSP_ABORT: begin drop  <= 1'b1; state <= ST_IDLE; end
                        RSP_ERR:   begin retry <= 1'b1; state <= ST_IDLE; end
                        RSP_ACK:   begin done  <= 1'b1; state <= ST_IDLE; end
                        default: ;
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/appbus_xfer_master.sv
// Bus master that moves one packet between the device core and the
// application bus, with ack/err/abort handling and a status write after
// deliver packets. Assumes i_out_word follows o_word_idx combinationally.
module appbus_xfer_master
    import appbus_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 11,
    localparam int BEN_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_pkt_start,
    input  logic              i_pkt_rd,
    input  logic [ADDR_W-1:0] i_pkt_addr,
    input  logic [LEN_W-1:0]  i_pkt_len,
    input  logic [ADDR_W-1:0] i_stat_addr,
    input  logic [DATA_W-1:0] i_out_word,
    output logic [LEN_W-1:0]  o_word_idx,
    output logic              o_busy,
    output logic              o_in_valid,
    output logic [DATA_W-1:0] o_in_data,
    output logic [BEN_W-1:0]  o_in_ben,
    output logic              o_pkt_done,
    output logic              o_pkt_retry,
    output logic              o_pkt_drop,
    output logic              o_cmd_valid,
    output logic [ADDR_W-1:0] o_addr,
    output logic              o_rnw,
    output logic [DATA_W-1:0] o_wdata,
    output logic [BEN_W-1:0]  o_ben,
    output logic              o_burst,
    input  logic              i_ack,
    input  logic              i_err,
    input  logic              i_abort,
    input  logic [DATA_W-1:0] i_rdata,
    input  logic [BEN_W-1:0]  i_rben
);
    xfer_state_t       state;
    xfer_resp_t        resp;
    logic [ADDR_W-1:0] base, stat_addr, beat_addr;
    logic [LEN_W-1:0]  len, idx;
    logic [BEN_W-1:0]  beat_ben;
    logic              rd, last;

    xfer_resp_arb u_arb (
        .cmd_active (o_cmd_valid),
        .ack        (i_ack),
        .err        (i_err),
        .abort      (i_abort),
        .resp       (resp)
    );

    xfer_beat_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_beat (
        .base (base),
        .len  (len),
        .idx  (idx),
        .addr (beat_addr),
        .ben  (beat_ben),
        .last (last)
    );

    xfer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (i_pkt_start),
        .start_rd   (i_pkt_rd),
        .start_addr (i_pkt_addr),
        .start_len  (i_pkt_len),
        .start_stat (i_stat_addr),
        .resp       (resp),
        .last       (last),
        .rdata      (i_rdata),
        .rben       (i_rben),
        .state      (state),
        .base       (base),
        .len        (len),
        .idx        (idx),
        .rd         (rd),
        .stat_addr  (stat_addr),
        .done       (o_pkt_done),
        .retry      (o_pkt_retry),
        .drop       (o_pkt_drop),
        .in_valid   (o_in_valid),
        .in_data    (o_in_data),
        .in_ben     (o_in_ben)
    );

    // Bus field selection between data words and the status write
    always_comb begin
        o_cmd_valid = (state != ST_IDLE);
        o_busy      = o_cmd_valid;
        o_word_idx  = idx;
        if (state == ST_STAT) begin
            o_addr  = stat_addr;
            o_rnw   = 1'b0;
            o_wdata = {{(DATA_W-LEN_W){1'b0}}, len};
            o_ben   = '1;
            o_burst = 1'b0;
        end else begin
            o_addr  = beat_addr;
            o_rnw   = (state == ST_DATA) && rd;
            o_wdata = i_out_word;
            o_ben   = beat_ben;
            o_burst = (state == ST_DATA) && !last;
        end
    end
endmodule

// File: rtl/appbus_xfer_master_chk.sv
// Property checker for the transfer master, bound to every instance.
// Assumes write data from the core is stable while its index is stable.
module appbus_xfer_master_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int BEN_W = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              o_cmd_valid,
    input logic [ADDR_W-1:0] o_addr,
    input logic              o_rnw,
    input logic [DATA_W-1:0] o_wdata,
    input logic [BEN_W-1:0]  o_ben,
    input logic              o_burst,
    input logic              o_in_valid,
    input logic              o_pkt_done,
    input logic              o_pkt_retry,
    input logic              o_pkt_drop,
    input logic              i_ack,
    input logic              i_err,
    input logic              i_abort
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !o_cmd_valid && !o_pkt_done && !o_pkt_retry && !o_pkt_drop);

    assert_hold_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        o_cmd_valid && !i_ack && !i_err && !i_abort |=>
        o_cmd_valid && $stable(o_addr) && $stable(o_rnw) && $stable(o_ben)
        && $stable(o_burst) && $stable(o_wdata));

    assert_burst_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        o_cmd_valid && o_burst |-> o_ben == {BEN_W{1'b1}});

    assert_read_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        o_cmd_valid && o_rnw && i_ack && !i_err && !i_abort |=> o_in_valid);

    assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        o_cmd_valid && i_err && !i_abort |=> !o_cmd_valid && o_pkt_retry);

    assert_abort_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        o_cmd_valid && i_abort |=> !o_cmd_valid && o_pkt_drop && !o_pkt_done);

    assert_one_outcome_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_pkt_done, o_pkt_retry, o_pkt_drop}));
endmodule

bind appbus_xfer_master appbus_xfer_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .o_cmd_valid (o_cmd_valid),
    .o_addr      (o_addr),
    .o_rnw       (o_rnw),
    .o_wdata     (o_wdata),
    .o_ben       (o_ben),
    .o_burst     (o_burst),
    .o_in_valid  (o_in_valid),
    .o_pkt_done  (o_pkt_done),
    .o_pkt_retry (o_pkt_retry),
    .o_pkt_drop  (o_pkt_drop),
    .i_ack       (i_ack),
    .i_err       (i_err),
    .i_abort     (i_abort)
);

// File: tb/appbus_xfer_master_tb_top.sv
// Bench: scripted responder, behavioural per-clock model, directed counts.
module appbus_xfer_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, pkt_rd = 1'b0;
    logic [15:0] pkt_addr = '0, stat_addr = '0;
    logic [10:0] pkt_len = '0;
    logic [31:0] out_word;
    logic [10:0] word_idx;
    logic        busy, in_valid, done, retry, drop;
    logic [31:0] in_data, wdata;
    logic [3:0]  in_ben, ben;
    logic        cmd, rnw, burst;
    logic [15:0] addr;
    logic        ack = 1'b0, err = 1'b0, abort = 1'b0;
    logic [31:0] rdata = '0;
    logic [3:0]  rben = '0;

    always #5 clk = ~clk;

    assign out_word = 32'hC0DE0000 | {21'd0, word_idx};

    appbus_xfer_master dut_i (
        .clk(clk), .rst_n(rst_n), .i_pkt_start(start), .i_pkt_rd(pkt_rd),
        .i_pkt_addr(pkt_addr), .i_pkt_len(pkt_len), .i_stat_addr(stat_addr),
        .i_out_word(out_word), .o_word_idx(word_idx), .o_busy(busy),
        .o_in_valid(in_valid), .o_in_data(in_data), .o_in_ben(in_ben),
        .o_pkt_done(done), .o_pkt_retry(retry), .o_pkt_drop(drop),
        .o_cmd_valid(cmd), .o_addr(addr), .o_rnw(rnw), .o_wdata(wdata),
        .o_ben(ben), .o_burst(burst), .i_ack(ack), .i_err(err),
        .i_abort(abort), .i_rdata(rdata), .i_rben(rben)
    );

    // Response script: 0 wait, 1 ack, 2 err, 3 abort, 4 ack+err, 5 all three
    int resp_q[$];

    // Scripted responder, driven after each edge
    always @(posedge clk) begin
        int code;
        #2;
        code = 0;
        if (cmd) code = (resp_q.size() > 0) ? resp_q.pop_front() : 1;
        ack   = (code == 1) || (code == 4) || (code == 5);
        err   = (code == 2) || (code == 4) || (code == 5);
        abort = (code == 3) || (code == 5);
        rdata = {addr, ~addr};
        rben  = addr[5:2] ^ 4'hA;
    end

    // Behavioural reference model
    int          m_act = 0, m_idx = 0, m_len = 0;
    logic [15:0] m_base = '0, m_stat = '0;
    logic        m_rd = 0, m_done = 0, m_retry = 0, m_drop = 0, m_inv = 0;
    logic [31:0] m_indata = '0;
    logic [3:0]  m_inben = '0;

    function automatic int nwords(int l);
        return (l + 3) / 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_done = 0; m_retry = 0; m_drop = 0; m_inv = 0;
        end else begin
            m_done = 0; m_retry = 0; m_drop = 0; m_inv = 0;
            if (m_act == 0) begin
                if (start) begin
                    m_base = pkt_addr; m_len = int'(pkt_len); m_rd = pkt_rd;
                    m_stat = stat_addr; m_idx = 0;
                    if (m_len == 0) begin
                        if (m_rd) m_done = 1; else m_act = 2;
                    end else m_act = 1;
                end
            end else if (abort) begin m_drop = 1; m_act = 0; end
            else if (err) begin m_retry = 1; m_act = 0; end
            else if (ack) begin
                if (m_act == 2) begin m_done = 1; m_act = 0; end
                else begin
                    if (m_rd) begin m_inv = 1; m_indata = rdata; m_inben = rben; end
                    if (m_idx == nwords(m_len) - 1) begin
                        if (m_rd) begin m_done = 1; m_act = 0; end else m_act = 2;
                    end else m_idx++;
                end
            end
        end
    end

    int m_checks = 0, m_errors = 0, d_checks = 0, d_errors = 0, cycles = 0;
    int cnt_done = 0, cnt_retry = 0, cnt_drop = 0, cnt_inv = 0, cnt_cmd = 0, cnt_stat = 0;

    task automatic mcheck(input string tag, input logic [31:0] got, input logic [31:0] exp);
        m_checks++;
        if (got !== exp) begin
            m_errors++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison, event counters and watchdog
    always @(negedge clk) begin
        logic [15:0] e_addr;
        logic [3:0]  e_ben;
        logic [31:0] e_wdata;
        logic        e_burst, e_rnw;
        int          r;
        cycles++;
        if (cycles > 20000) begin
            m_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", m_checks + d_checks, m_errors + d_errors);
            $finish;
        end
        if (rst_n) begin
            mcheck("R2 cmd_valid", {31'd0, cmd}, {31'd0, m_act != 0});
            mcheck("R11 busy", {31'd0, busy}, {31'd0, m_act != 0});
            mcheck("R13 done", {31'd0, done}, {31'd0, m_done});
            mcheck("R8 retry", {31'd0, retry}, {31'd0, m_retry});
            mcheck("R9 drop", {31'd0, drop}, {31'd0, m_drop});
            mcheck("R6 in_valid", {31'd0, in_valid}, {31'd0, m_inv});
            if (m_inv) begin
                mcheck("R6 in_data", in_data, m_indata);
                mcheck("R6 in_ben", {28'd0, in_ben}, {28'd0, m_inben});
            end
            if (m_act != 0) begin
                if (m_act == 2) begin
                    e_addr = m_stat; e_rnw = 0; e_ben = 4'hF; e_burst = 0;
                    e_wdata = 32'(m_len);
                end else begin
                    e_addr = m_base + 16'(4 * m_idx);
                    e_rnw = m_rd;
                    e_burst = (m_idx != nwords(m_len) - 1);
                    r = m_len % 4;
                    e_ben = (e_burst || r == 0) ? 4'hF : 4'((1 << r) - 1);
                    e_wdata = 32'hC0DE0000 | 32'(m_idx);
                end
                mcheck("R2 addr", {16'd0, addr}, {16'd0, e_addr});
                mcheck("R2 rnw", {31'd0, rnw}, {31'd0, e_rnw});
                mcheck("R4 burst", {31'd0, burst}, {31'd0, e_burst});
                mcheck("R5 ben", {28'd0, ben}, {28'd0, e_ben});
                if (!e_rnw) mcheck("R7 wdata", wdata, e_wdata);
            end
            cnt_done  += int'(done);
            cnt_retry += int'(retry);
            cnt_drop  += int'(drop);
            cnt_inv   += int'(in_valid);
            cnt_cmd   += int'(cmd && (ack || err || abort));
            cnt_stat  += int'(cmd && addr == 16'hF000 && !rnw);
        end
    end

    task automatic dcheck(input string tag, input int got, input int exp);
        d_checks++;
        if (got != exp) begin
            d_errors++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    int b_done, b_retry, b_drop, b_inv, b_cmd, b_stat;

    task automatic snap();
        b_done = cnt_done; b_retry = cnt_retry; b_drop = cnt_drop;
        b_inv = cnt_inv; b_cmd = cnt_cmd; b_stat = cnt_stat;
    endtask

    task automatic pulse_start(input logic rdv, input logic [15:0] a, input int l);
        @(posedge clk); #2;
        start = 1'b1; pkt_rd = rdv; pkt_addr = a; pkt_len = 11'(l); stat_addr = 16'hF000;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic run_pkt(input logic rdv, input logic [15:0] a, input int l);
        snap();
        pulse_start(rdv, a, l);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        dcheck("R1 cmd in reset", int'(cmd), 0);
        dcheck("R1 busy in reset", int'(busy), 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        dcheck("R1 cmd after reset", int'(cmd), 0);
        dcheck("R1 pulses after reset", int'(done | retry | drop | in_valid), 0);

        // Deliver packet, 10 bytes, all acked, then status write
        run_pkt(1'b0, 16'h0100, 10);
        dcheck("R7 done after status", cnt_done - b_done, 1);
        dcheck("R7 one status write", cnt_stat - b_stat, 1);
        dcheck("R2 cycles for 10 bytes", cnt_cmd - b_cmd, 4);

        // Fetch packet, 7 bytes, with wait states (R3)
        resp_q = '{0, 0, 1, 0, 1};
        run_pkt(1'b1, 16'h2000, 7);
        dcheck("R13 fetch done", cnt_done - b_done, 1);
        dcheck("R6 fetched words", cnt_inv - b_inv, 2);
        dcheck("R13 no status on fetch", cnt_stat - b_stat, 0);

        // Error on second word of a deliver packet, then replay
        resp_q = '{1, 2};
        run_pkt(1'b0, 16'h0300, 8);
        dcheck("R8 retry pulse", cnt_retry - b_retry, 1);
        dcheck("R8 cycles before stop", cnt_cmd - b_cmd, 2);
        dcheck("R8 no status after err", cnt_stat - b_stat, 0);
        run_pkt(1'b0, 16'h0300, 8);
        dcheck("R8 replay completes", cnt_done - b_done, 1);

        // Abort on the first fetch word
        resp_q = '{3};
        run_pkt(1'b1, 16'h4000, 5);
        dcheck("R9 drop pulse", cnt_drop - b_drop, 1);
        dcheck("R9 no data after abort", cnt_inv - b_inv, 0);

        // Abort during the status write
        resp_q = '{1, 3};
        run_pkt(1'b0, 16'h0500, 4);
        dcheck("R9 drop in status", cnt_drop - b_drop, 1);
        dcheck("R9 no done in status", cnt_done - b_done, 0);

        // Coinciding responses
        resp_q = '{4};
        run_pkt(1'b0, 16'h0600, 4);
        dcheck("R10 err over ack", cnt_retry - b_retry, 1);
        dcheck("R10 no done on err+ack", cnt_done - b_done, 0);
        resp_q = '{5};
        run_pkt(1'b1, 16'h0700, 4);
        dcheck("R10 abort over all", cnt_drop - b_drop, 1);
        dcheck("R10 no data when ack loses", cnt_inv - b_inv, 0);

        // Start while busy is ignored
        resp_q = '{0, 0, 0, 0, 1, 1, 1};
        snap();
        pulse_start(1'b0, 16'h0800, 8);
        pulse_start(1'b1, 16'h9000, 12);
        for (int i = 0; i < 50; i++) @(negedge clk);
        dcheck("R11 one completion only", cnt_done - b_done, 1);
        dcheck("R11 no extra cycles", cnt_cmd - b_cmd, 3);

        // Zero length packets
        run_pkt(1'b1, 16'h0A00, 0);
        dcheck("R12 empty fetch done", cnt_done - b_done, 1);
        dcheck("R12 empty fetch no cycle", cnt_cmd - b_cmd, 0);
        run_pkt(1'b0, 16'h0B00, 0);
        dcheck("R12 empty deliver status only", cnt_stat - b_stat, 1);
        dcheck("R12 empty deliver cycles", cnt_cmd - b_cmd, 1);

        // Single-word lengths and a long burst (R4, R5)
        for (int l = 1; l <= 4; l++) begin
            run_pkt(1'b0, 16'h0C00, l);
            dcheck("R5 single word cycles", cnt_cmd - b_cmd, 2);
        end
        run_pkt(1'b1, 16'hFFF0, 64);
        dcheck("R4 long fetch words", cnt_inv - b_inv, 16);

        $display("CHECKS %0d ERRORS %0d", m_checks + d_checks, m_errors + d_errors);
        $finish;
    end
endmodule